// File: doc/BRIEF.md
# Sweeping Quadrature Down-Mix Front End

This block turns a stream of real 16-bit samples into an in-phase and a quadrature product stream for two matched lowpass chains that follow it. Each accepted sample is multiplied by the cosine (I path) and the sine (Q path) of a 34-bit phase accumulator. The frequency word driving that accumulator can stay fixed, jump to a preloaded word, or ramp linearly up or down by a fixed step on every sample, so the same hardware produces a steady tone, a hopping carrier or a chirp.

Samples arrive as two's complement or offset binary, selected by a configuration bit. A bypass setting freezes the synthesizer and forwards the sample on the I path with Q held at zero, so the following chains act as a plain lowpass filter. Every accepted sample gives exactly one output pair a fixed three clocks later.

Top module: `chirp_mixer`

## Requirements
- R1: With `cfg_offset_bin` high, the sample value is the raw word minus 32768, obtained by inverting its most significant bit; with it low, the raw word is read as two's complement.
- R2: A sample accepted with `in_valid` high in one cycle yields `out_valid` high exactly three cycles later, for one cycle, and `out_valid` is never high otherwise.
- R3: When not bypassed, `out_i` = floor((x*C + 2048) / 4096) and `out_q` = floor((x*S + 2048) / 4096), where x is the sample value and C and S are round(32767*cos(a)) and round(32767*sin(a)) with a = 2*pi*(p+0.5)/1024 and p the top 10 bits of the phase at acceptance.
- R4: The phase starts at zero and advances by the current frequency word, modulo 2^34, only when a sample is accepted without bypass.
- R5: With `cfg_mode` = 0 (fixed tone) the frequency word changes only through `tune_load`.
- R6: With `cfg_mode` = 2 (upward sweep) each accepted sample adds `sweep_step` to the frequency word, modulo 2^34, after the sample has used the old word.
- R7: With `cfg_mode` = 3 (downward sweep) each accepted sample subtracts `sweep_step` from the frequency word, modulo 2^34.
- R8: A pulse on `hop_arm` captures `hop_word` as pending; with `cfg_mode` = 1 the pending word replaces the frequency word at the next accepted sample after the pulse cycle, never at the sample of the pulse cycle, and the pending word is consumed.
- R9: With `cfg_bypass` high at acceptance, `out_i` equals the sample value times 8, `out_q` is zero, and phase and frequency do not move.
- R10: After reset the outputs are zero, `out_valid` is low, and phase and frequency are zero.
- R11: `tune_load` writes `tune_word` into the frequency word and takes priority over sweep and hop updates in the same cycle; a hop pending at that time stays pending.
- R12: While `out_valid` is low, `out_i` and `out_q` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_offset_bin | input | 1 | Sample format: 1 offset binary, 0 two's complement |
| cfg_bypass | input | 1 | Bypass the synthesizer and mixer |
| cfg_mode | input | 2 | 0 tone, 1 hop, 2 upward sweep, 3 downward sweep |
| tune_load | input | 1 | Write `tune_word` into the frequency word |
| tune_word | input | 34 | Frequency word to load |
| sweep_step | input | 34 | Frequency change per sample in sweep modes |
| hop_arm | input | 1 | Capture `hop_word` as the pending hop |
| hop_word | input | 34 | Frequency word for the next hop |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 16 | Raw input sample |
| out_valid | output | 1 | Output pair present this cycle |
| out_i | output | 20 | In-phase (cosine) product, signed |
| out_q | output | 20 | Quadrature (sine) product, signed |

## Verification
The assertions assume that configuration inputs are steady while a sample is being accepted and that reset is held long enough to clear the three pipeline stages; the latency and bypass properties also rely on `in_valid` being a clean per-cycle qualifier with no meaning while reset is low. The stimulus changes configuration only on the falling edge, keeps `in_valid` low throughout reset, and drives `hop_arm` and `tune_load` as single-cycle pulses, including pulses that coincide with accepted samples and with each other.

// File: rtl/chirp_mixer.sv
module chirp_mixer #(
  parameter int DW   = 16,
  parameter int PW   = 34,
  parameter int LUTA = 10,
  parameter int AMPW = 16,
  parameter int OW   = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_offset_bin,
  input  logic                 cfg_bypass,
  input  logic [1:0]           cfg_mode,
  input  logic                 tune_load,
  input  logic [PW-1:0]        tune_word,
  input  logic [PW-1:0]        sweep_step,
  input  logic                 hop_arm,
  input  logic [PW-1:0]        hop_word,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_sample,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);

  localparam int QB   = LUTA - 2;
  localparam int QN   = 1 << QB;
  localparam int PRW  = DW + AMPW;
  localparam int SH   = PRW - OW;
  localparam longint AMP   = (64'sd1 <<< (AMPW - 1)) - 1;
  localparam longint PI_FX = 64'sd3373259426;

  localparam logic [1:0] M_TONE = 2'd0;
  localparam logic [1:0] M_HOP  = 2'd1;
  localparam logic [1:0] M_UP   = 2'd2;
  localparam logic [1:0] M_DOWN = 2'd3;

  function automatic logic [QN-1:0][AMPW-1:0] build_quarter();
    logic [QN-1:0][AMPW-1:0] t;
    longint x, x2, term, acc;
    for (int k = 0; k < QN; k++) begin
      x    = (longint'(2 * k + 1) * PI_FX) / longint'(4 * QN);
      x2   = (x * x) >>> 30;
      term = x;
      acc  = x;
      for (int n = 1; n <= 6; n++) begin
        term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
        acc  = acc + term;
      end
      t[k] = AMPW'((acc * AMP + (64'sd1 <<< 29)) >>> 30);
    end
    return t;
  endfunction

  localparam logic [QN-1:0][AMPW-1:0] QUARTER = build_quarter();

  function automatic logic signed [AMPW-1:0] wave(input logic [LUTA-1:0] a);
    logic [QB-1:0]   idx;
    logic [AMPW-1:0] mag;
    idx = a[LUTA-2] ? ~a[QB-1:0] : a[QB-1:0];
    mag = QUARTER[idx];
    return a[LUTA-1] ? -$signed(mag) : $signed(mag);
  endfunction

  logic [PW-1:0]   phase_q, freq_q, hop_word_q;
  logic            hop_pend_q;
  logic            accept, hop_apply;
  logic [LUTA-1:0] sin_addr, cos_addr;
  logic signed [DW-1:0] x_conv;

  assign accept    = in_valid && !cfg_bypass;
  assign hop_apply = accept && !tune_load && cfg_mode == M_HOP && hop_pend_q;
  assign sin_addr  = phase_q[PW-1 -: LUTA];
  assign cos_addr  = sin_addr + LUTA'(QN);
  assign x_conv    = $signed({in_sample[DW-1] ^ cfg_offset_bin, in_sample[DW-2:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (accept) phase_q <= phase_q + freq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) freq_q <= '0;
    else if (tune_load) freq_q <= tune_word;
    else if (accept) begin
      case (cfg_mode)
        M_HOP:   if (hop_pend_q) freq_q <= hop_word_q;
        M_UP:    freq_q <= freq_q + sweep_step;
        M_DOWN:  freq_q <= freq_q - sweep_step;
        default: freq_q <= freq_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hop_pend_q <= 1'b0;
      hop_word_q <= '0;
    end else if (hop_arm) begin
      hop_pend_q <= 1'b1;
      hop_word_q <= hop_word;
    end else if (hop_apply) begin
      hop_pend_q <= 1'b0;
    end
  end

  logic                   v1, byp1, v2;
  logic signed [DW-1:0]   x1;
  logic signed [AMPW-1:0] cos1, sin1;
  logic signed [PRW-1:0]  pi2, pq2;
  logic signed [OW-1:0]   ri, rq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      byp1 <= 1'b0;
      x1   <= '0;
      cos1 <= '0;
      sin1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        x1   <= x_conv;
        byp1 <= cfg_bypass;
        cos1 <= wave(cos_addr);
        sin1 <= wave(sin_addr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2  <= 1'b0;
      pi2 <= '0;
      pq2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        pi2 <= byp1 ? (PRW'(x1) <<< (AMPW - 1)) : PRW'(x1) * PRW'(cos1);
        pq2 <= byp1 ? '0 : PRW'(x1) * PRW'(sin1);
      end
    end
  end

  assign ri = OW'((pi2 + PRW'(1 << (SH - 1))) >>> SH);
  assign rq = OW'((pq2 + PRW'(1 << (SH - 1))) >>> SH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        out_i <= ri;
        out_q <= rq;
      end
    end
  end

endmodule

// File: rtl/chirp_mixer_chk.sv
module chirp_mixer_chk #(
  parameter int PW = 34,
  parameter int OW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_bypass,
  input logic [1:0]    cfg_mode,
  input logic          tune_load,
  input logic [PW-1:0] tune_word,
  input logic [PW-1:0] sweep_step,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_i,
  input logic [OW-1:0] out_q,
  input logic [PW-1:0] phase_q,
  input logic [PW-1:0] freq_q,
  input logic          hop_pend_q,
  input logic [PW-1:0] hop_word_q
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  assert_bypass_q_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && cfg_bypass, 3)) |-> out_q == '0);

  assert_phase_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || cfg_bypass) |=> $stable(phase_q));

  assert_tone_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tune_load && cfg_mode == 2'd0) |=> $stable(freq_q));

  assert_sweep_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_bypass && !tune_load && cfg_mode == 2'd2)
      |=> freq_q == $past(freq_q) + $past(sweep_step));

  assert_sweep_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_bypass && !tune_load && cfg_mode == 2'd3)
      |=> freq_q == $past(freq_q) - $past(sweep_step));

  assert_hop_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_bypass && !tune_load && cfg_mode == 2'd1 && hop_pend_q)
      |=> freq_q == $past(hop_word_q));

  assert_tune_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tune_load |=> freq_q == $past(tune_word));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind chirp_mixer chirp_mixer_chk #(.PW(PW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_bypass (cfg_bypass),
  .cfg_mode   (cfg_mode),
  .tune_load  (tune_load),
  .tune_word  (tune_word),
  .sweep_step (sweep_step),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_i      (out_i),
  .out_q      (out_q),
  .phase_q    (phase_q),
  .freq_q     (freq_q),
  .hop_pend_q (hop_pend_q),
  .hop_word_q (hop_word_q)
);

// File: tb/tb_chirp_mixer.sv
module tb_chirp_mixer;
  localparam int  PW     = 34;
  localparam time PERIOD = 10ns;
  localparam int  TOL    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_offset_bin = 1'b0, cfg_bypass = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic tune_load = 1'b0, hop_arm = 1'b0, in_valid = 1'b0;
  logic [PW-1:0] tune_word = '0, sweep_step = '0, hop_word = '0;
  logic [15:0] in_sample = '0;
  logic out_valid;
  logic signed [19:0] out_i, out_q;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  chirp_mixer dut (
    .clk(clk), .rst_n(rst_n), .cfg_offset_bin(cfg_offset_bin), .cfg_bypass(cfg_bypass),
    .cfg_mode(cfg_mode), .tune_load(tune_load), .tune_word(tune_word),
    .sweep_step(sweep_step), .hop_arm(hop_arm), .hop_word(hop_word),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wref(input longint p, input bit cosine);
    real a, v;
    a = 2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 1024.0;
    v = 32767.0 * (cosine ? $cos(a) : $sin(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  typedef struct { longint due; longint i; longint q; bit exact; } exp_t;
  exp_t eq[$];
  longint unsigned MASK = (64'd1 << PW) - 1;
  longint unsigned ph_m, fr_m, hw_m;
  bit hp_m;
  longint cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph_m = 0; fr_m = 0; hw_m = 0; hp_m = 0; eq.delete();
    end else begin
      exp_t e;
      longint x, p;
      bit acc, take;
      cyc++;
      if (in_valid) begin
        x = cfg_offset_bin ? longint'(in_sample) - 32768 : longint'($signed(in_sample)); // R1
        e.due = cyc + 2;
        if (cfg_bypass) begin
          e.i = x * 8; e.q = 0; e.exact = 1'b1;                                        // R9
        end else begin
          p = longint'(ph_m >> (PW - 10));
          e.i = (x * wref(p, 1'b1) + 2048) >>> 12;                                     // R3
          e.q = (x * wref(p, 1'b0) + 2048) >>> 12;
          e.exact = 1'b0;
        end
        eq.push_back(e);
      end
      acc  = in_valid && !cfg_bypass;
      take = acc && !tune_load && cfg_mode == 2'd1 && hp_m;
      if (acc) ph_m = (ph_m + fr_m) & MASK;                                            // R4
      if (tune_load) fr_m = tune_word;                                                 // R11
      else if (acc) begin
        if (cfg_mode == 2'd1 && hp_m) fr_m = hw_m;                                     // R8
        else if (cfg_mode == 2'd2) fr_m = (fr_m + sweep_step) & MASK;                  // R6
        else if (cfg_mode == 2'd3) fr_m = (fr_m - sweep_step) & MASK;                  // R7
      end
      if (hop_arm) begin hp_m = 1'b1; hw_m = hop_word; end
      else if (take) hp_m = 1'b0;
    end
  end

  longint last_i = 0, last_q = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (eq.size() > 0 && eq[0].due == cyc) begin
        exp_t e;
        e = eq.pop_front();
        check(out_valid === 1'b1, "R2 out_valid", longint'(out_valid), 1);
        if (e.exact) begin
          check(longint'(out_i) == e.i, "R9 bypass I", longint'(out_i), e.i);
          check(longint'(out_q) == 0, "R9 bypass Q", longint'(out_q), 0);
        end else begin
          check(longint'(out_i) - e.i <= TOL && e.i - longint'(out_i) <= TOL,
                "R3 I product", longint'(out_i), e.i);
          check(longint'(out_q) - e.q <= TOL && e.q - longint'(out_q) <= TOL,
                "R3 Q product", longint'(out_q), e.q);
        end
      end else begin
        check(out_valid === 1'b0, "R2 no stray valid", longint'(out_valid), 0);
        check(longint'(out_i) == last_i && longint'(out_q) == last_q,
              "R12 hold", longint'(out_i), last_i);
      end
      last_i = longint'(out_i);
      last_q = longint'(out_q);
    end
  end

  task automatic tick(input bit v, input logic [15:0] s, input bit tl = 1'b0, input bit ha = 1'b0);
    @(negedge clk);
    in_valid  = v;
    in_sample = s;
    tune_load = tl;
    hop_arm   = ha;
  endtask

  task automatic burst(input int n, input int dens);
    for (int k = 0; k < n; k++) tick(($urandom % 100) < dens, 16'($urandom));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 valid after reset", longint'(out_valid), 0);
    check(out_i == 0 && out_q == 0, "R10 outputs after reset", longint'(out_i), 0);

    tick(1'b1, 16'h4000);                                       // R4: phase 0 first
    tick(1'b1, 16'h8000);
    tick(1'b0, 16'h0);

    tune_word = 34'h0_2345_6789;                                // R5 tone
    tick(1'b0, 16'h0, 1'b1);
    burst(200, 75);

    cfg_offset_bin = 1'b1;                                      // R1
    tick(1'b1, 16'h0000); tick(1'b1, 16'hFFFF);
    tick(1'b1, 16'h8000); tick(1'b1, 16'h7FFF);
    burst(100, 80);
    cfg_offset_bin = 1'b0;

    cfg_mode = 2'd2; sweep_step = 34'h0_0012_3456;              // R6
    burst(200, 90);
    cfg_mode = 2'd3; sweep_step = 34'h0_0123_4567;              // R7, wraps
    burst(200, 90);

    cfg_mode = 2'd1;                                            // R8
    hop_word = 34'h1_1111_0000;
    tick(1'b0, 16'h0, 1'b0, 1'b1);
    burst(20, 100);
    hop_word = 34'h2_ABCD_0123;
    tick(1'b1, 16'h1234, 1'b0, 1'b1);                           // arm with a sample
    tick(1'b1, 16'h5678);
    burst(20, 100);
    hop_word = 34'h0_0F0F_F0F0; tune_word = 34'h3_0000_0001;    // R11
    tick(1'b1, 16'h2222, 1'b0, 1'b1);
    tick(1'b1, 16'h3333, 1'b1, 1'b0);
    tick(1'b1, 16'h4444);
    burst(30, 70);

    cfg_mode = 2'd0; cfg_bypass = 1'b1;                         // R9
    tick(1'b1, 16'h8000); tick(1'b1, 16'h7FFF);
    tick(1'b1, 16'h0001); tick(1'b1, 16'hFFFF);
    burst(60, 70);
    cfg_offset_bin = 1'b1;
    tick(1'b1, 16'h0000); tick(1'b1, 16'hFFFF);
    cfg_offset_bin = 1'b0; cfg_bypass = 1'b0;
    burst(50, 60);

    for (int k = 0; k < 64; k++) tick(1'b1, (k % 2) ? 16'h8000 : 16'h7FFF);  // R3 extremes

    repeat (8) tick(1'b0, 16'h0);
    check(eq.size() == 0, "R2 all outputs delivered", longint'(eq.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule